// File: doc/BRIEF.md
# I2C 10-bit Slave Address Matcher

This block is the address-recognition engine of an I2C slave that owns a 10-bit address. A bus front end, which handles line sampling and bit shifting, hands it byte-level events: START, repeated START, STOP, and each received byte with a one-cycle strobe. For every byte the matcher decides whether the slave drives an acknowledge. It also tracks whether the slave is selected and whether it acts as receiver or transmitter.

A write transfer selects the slave through two address bytes. The first byte is a header: the pattern 11110, the two high own-address bits, and the read/write bit. The second byte is the low eight own-address bits. The matcher remembers a successful selection across a repeated START. A read can therefore be entered with the header byte alone, sent with the read bit set. When a header byte is accepted, the matcher raises a first-byte event. The byte taken in that step is flagged as address, not payload.

Top module: `i2c10_addr_match`

## Requirements
- R1: Synchronous reset drives `ack_req`, `first_byte_evt`, `data_ok`, `addressed` and `slave_tx` low. Reset also clears the remembered-selection state.
- R2: After a START, a byte equal to {11110, own_addr[9:8], 0} (read/write in bit 0, 0 meaning write) is acknowledged and raises `first_byte_evt`. The slave does not become addressed on this byte.
- R3: The byte that follows an accepted write header is acknowledged when it equals own_addr[7:0]. The slave then becomes addressed as a receiver (`addressed`=1, `slave_tx`=0).
- R4: A second byte that differs from own_addr[7:0] is not acknowledged and leaves the slave unaddressed. Every further byte of that transfer gets no acknowledge and no `data_ok`.
- R5: After a START, a header whose upper seven bits differ from {11110, own_addr[9:8]} is not acknowledged. The rest of the transfer is ignored, even a byte equal to own_addr[7:0].
- R6: After a repeated START, a slave that was selected earlier in the transaction acknowledges a read header {11110, own_addr[9:8], 1}. It raises `first_byte_evt` and becomes addressed as a transmitter (`slave_tx`=1).
- R7: A read header that follows a plain START, with no earlier selection, is not acknowledged. The slave stays unaddressed.
- R8: A STOP or a plain START drops `addressed` and the remembered selection. A later repeated START followed by a read header is then not acknowledged.
- R9: The slave stays addressed across a repeated START until the next header byte has been judged. A header that does not match drops `addressed` and the remembered selection.
- R10: While addressed as a receiver, every data byte is acknowledged and pulses `data_ok`. While addressed as a transmitter, bytes get no acknowledge and no `data_ok`. Address bytes never pulse `data_ok`.
- R11: `ack_req`, `first_byte_evt` and `data_ok` are one-cycle pulses. They appear in the cycle after the byte strobe and are low again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| own_addr | input | 10 | The slave's own 10-bit address |
| ev_start | input | 1 | One-cycle pulse: START seen on the bus |
| ev_rstart | input | 1 | One-cycle pulse: repeated START seen |
| ev_stop | input | 1 | One-cycle pulse: STOP seen |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| byte_data | input | 8 | Received byte, MSB first on the bus, read/write bit in bit 0 |
| ack_req | output | 1 | Pulse: drive acknowledge for the byte just received |
| first_byte_evt | output | 1 | Pulse: a header byte was accepted (its content is not data) |
| data_ok | output | 1 | Pulse: the byte just received is valid payload |
| addressed | output | 1 | Slave currently selected |
| slave_tx | output | 1 | Selected slave acts as transmitter |

## Verification
Every byte result is registered once, so `ack_req`, `first_byte_evt`, `data_ok` and the updated `addressed`/`slave_tx` levels are due on the first clock edge after the strobe. Bus events change the levels on the first edge after their pulse. The driver queues the expected result of each byte as it raises the strobe. The monitor pops and compares that result at the falling edge that follows the first rising edge with the strobe seen. One cycle later the driver checks that the pulses have dropped again. Level checks after START, repeated START and STOP are made at the falling edge after the event pulse has been taken.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;

    localparam int ADDR_W = 10;
    localparam int BYTE_W = 8;
    localparam int HI_W   = ADDR_W - BYTE_W;
    localparam int PFX_W  = BYTE_W - 1 - HI_W;

    localparam logic [PFX_W-1:0] HDR_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_LOW,
        PH_RX,
        PH_TX,
        PH_SKIP
    } phase_t;

    typedef struct packed {
        logic hdr_hit;
        logic rd;
        logic low_hit;
    } cmp_t;

    typedef struct packed {
        logic ack;
        logic evt;
        logic dat;
    } pulse_t;

    typedef struct packed {
        logic sel;
        logic tx;
        logic prior;
    } sel_t;

    function automatic logic [BYTE_W-2:0] hdr_upper(input logic [ADDR_W-1:0] own);
        return {HDR_PREFIX, own[ADDR_W-1:BYTE_W]};
    endfunction

endpackage

// File: rtl/i2c10_cmp.sv
module i2c10_cmp
    import i2c10_pkg::*;
(
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] byte_data,
    output cmp_t              cmp
);
    always_comb begin
        cmp.hdr_hit = (byte_data[BYTE_W-1:1] == hdr_upper(own_addr));
        cmp.rd      = byte_data[0];
        cmp.low_hit = (byte_data == own_addr[BYTE_W-1:0]);
    end
endmodule

// File: rtl/i2c10_fsm.sv
module i2c10_fsm
    import i2c10_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ev_start,
    input  logic   ev_rstart,
    input  logic   ev_stop,
    input  logic   byte_vld,
    input  cmp_t   cmp,
    output pulse_t pulse_q,
    output sel_t   sel_q
);
    phase_t ph_q, ph_d;
    pulse_t pulse_d;
    sel_t   sel_d;

    always_comb begin
        ph_d    = ph_q;
        sel_d   = sel_q;
        pulse_d = '0;
        if (ev_stop) begin
            ph_d  = PH_IDLE;
            sel_d = '0;
        end else if (ev_start) begin
            ph_d  = PH_HDR;
            sel_d = '0;
        end else if (ev_rstart) begin
            ph_d  = PH_HDR;
        end else if (byte_vld) begin
            unique case (ph_q)
                PH_HDR: begin
                    if (cmp.hdr_hit && !cmp.rd) begin
                        pulse_d.ack = 1'b1;
                        pulse_d.evt = 1'b1;
                        ph_d        = PH_LOW;
                    end else if (cmp.hdr_hit && cmp.rd && sel_q.prior) begin
                        pulse_d.ack = 1'b1;
                        pulse_d.evt = 1'b1;
                        sel_d.sel   = 1'b1;
                        sel_d.tx    = 1'b1;
                        ph_d        = PH_TX;
                    end else begin
                        sel_d = '0;
                        ph_d  = PH_SKIP;
                    end
                end
                PH_LOW: begin
                    if (cmp.low_hit) begin
                        pulse_d.ack = 1'b1;
                        sel_d.sel   = 1'b1;
                        sel_d.tx    = 1'b0;
                        sel_d.prior = 1'b1;
                        ph_d        = PH_RX;
                    end else begin
                        sel_d = '0;
                        ph_d  = PH_SKIP;
                    end
                end
                PH_RX: begin
                    pulse_d.ack = 1'b1;
                    pulse_d.dat = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_IDLE;
            sel_q   <= '0;
            pulse_q <= '0;
        end else begin
            ph_q    <= ph_d;
            sel_q   <= sel_d;
            pulse_q <= pulse_d;
        end
    end

    // R10: a transmitting slave is always a selected slave
    assert_tx_needs_sel_R10: assert property (@(posedge clk) disable iff (rst)
        sel_q.tx |-> sel_q.sel);

    // R11: every acknowledge answers a strobe one cycle earlier
    assert_ack_after_strobe_R11: assert property (@(posedge clk) disable iff (rst)
        pulse_q.ack |-> $past(byte_vld));

    // R2: a header event is acknowledged and never flagged as payload
    assert_evt_not_data_R2: assert property (@(posedge clk) disable iff (rst)
        pulse_q.evt |-> (pulse_q.ack && !pulse_q.dat));

    // R8: STOP drops selection and memory
    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (!sel_q.sel && !sel_q.prior));

    // R6: entering transmit needs an earlier selection
    assert_tx_needs_prior_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_q.tx) |-> $past(sel_q.prior));

endmodule

// File: rtl/i2c10_addr_match.sv
module i2c10_addr_match
    import i2c10_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_stop,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              ack_req,
    output logic              first_byte_evt,
    output logic              data_ok,
    output logic              addressed,
    output logic              slave_tx
);
    cmp_t   cmp;
    pulse_t pulse;
    sel_t   sel;

    i2c10_cmp u_cmp (
        .own_addr  (own_addr),
        .byte_data (byte_data),
        .cmp       (cmp)
    );

    i2c10_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev_start  (ev_start),
        .ev_rstart (ev_rstart),
        .ev_stop   (ev_stop),
        .byte_vld  (byte_vld),
        .cmp       (cmp),
        .pulse_q   (pulse),
        .sel_q     (sel)
    );

    assign ack_req        = pulse.ack;
    assign first_byte_evt = pulse.evt;
    assign data_ok        = pulse.dat;
    assign addressed      = sel.sel;
    assign slave_tx       = sel.tx;

    // R11: pulses last a single cycle
    assert_ack_single_R11: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> !ack_req || $past(byte_vld));

endmodule

// File: tb/i2c10_addr_match_tb.sv
module i2c10_addr_match_tb;
    localparam logic [9:0] OWN  = 10'b10_1101_0011;
    localparam logic [7:0] HW   = 8'hF4;
    localparam logic [7:0] HR   = 8'hF5;
    localparam logic [7:0] HBAD = 8'hF6;
    localparam logic [7:0] LOK  = 8'hD3;
    localparam logic [7:0] LBAD = 8'hD2;

    typedef struct {
        logic  ack;
        logic  evt;
        logic  dat;
        logic  sel;
        logic  tx;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_start = 1'b0, ev_rstart = 1'b0, ev_stop = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic ack_req, first_byte_evt, data_ok, addressed, slave_tx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit seen = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    i2c10_addr_match u_dut (
        .clk(clk), .rst(rst), .own_addr(OWN),
        .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop),
        .byte_vld(byte_vld), .byte_data(byte_data),
        .ack_req(ack_req), .first_byte_evt(first_byte_evt), .data_ok(data_ok),
        .addressed(addressed), .slave_tx(slave_tx)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // monitor: compares the queued result one edge after each strobe
    always @(posedge clk) seen <= byte_vld;
    always @(negedge clk) begin
        if (seen && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.req, "ack_req", ack_req, e.ack);
            chk(e.req, "first_byte_evt", first_byte_evt, e.evt);
            chk(e.req, "data_ok", data_ok, e.dat);
            chk(e.req, "addressed", addressed, e.sel);
            chk(e.req, "slave_tx", slave_tx, e.tx);
        end
    end

    task automatic send(input logic [7:0] b, input logic a, input logic v, input logic d,
                        input logic s, input logic t, input string req);
        exp_t e;
        @(negedge clk);
        e.ack = a; e.evt = v; e.dat = d; e.sel = s; e.tx = t; e.req = req;
        sb.push_back(e);
        byte_vld  = 1'b1;
        byte_data = b;
        @(negedge clk);
        byte_vld = 1'b0;
        @(negedge clk);
        chk("R11", "ack_req low again", ack_req, 1'b0);
        chk("R11", "first_byte_evt low again", first_byte_evt, 1'b0);
        chk("R11", "data_ok low again", data_ok, 1'b0);
    endtask

    task automatic bus_ev(input int kind);
        @(negedge clk);
        if (kind == 0) ev_start = 1'b1;
        else if (kind == 1) ev_rstart = 1'b1;
        else ev_stop = 1'b1;
        @(negedge clk);
        ev_start = 1'b0; ev_rstart = 1'b0; ev_stop = 1'b0;
    endtask

    task automatic lvl(input string req, input logic s, input logic t);
        chk(req, "addressed", addressed, s);
        chk(req, "slave_tx", slave_tx, t);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ack_req", ack_req, 1'b0);
        chk("R1", "first_byte_evt", first_byte_evt, 1'b0);
        chk("R1", "data_ok", data_ok, 1'b0);
        lvl("R1", 1'b0, 1'b0);
        rst = 1'b0;
        // R1: no remembered selection after reset
        bus_ev(1);
        send(HR, 0, 0, 0, 0, 0, "R1");

        // write: header, low byte, data
        bus_ev(0);
        send(HW,   1, 1, 0, 0, 0, "R2");
        send(LOK,  1, 0, 0, 1, 0, "R3");
        send(8'h55, 1, 0, 1, 1, 0, "R10");
        send(8'h00, 1, 0, 1, 1, 0, "R10");
        bus_ev(2);
        lvl("R8", 1'b0, 1'b0);

        // read header without earlier selection
        bus_ev(0);
        send(HR,    0, 0, 0, 0, 0, "R7");
        send(8'hAA, 0, 0, 0, 0, 0, "R7");
        bus_ev(2);

        // bad header, then rest ignored
        bus_ev(0);
        send(HBAD, 0, 0, 0, 0, 0, "R5");
        send(LOK,  0, 0, 0, 0, 0, "R5");
        bus_ev(2);

        // bad low byte, then rest ignored
        bus_ev(0);
        send(HW,    1, 1, 0, 0, 0, "R2");
        send(LBAD,  0, 0, 0, 0, 0, "R4");
        send(8'h11, 0, 0, 0, 0, 0, "R4");
        bus_ev(2);

        // combined read through repeated START
        bus_ev(0);
        send(HW,  1, 1, 0, 0, 0, "R2");
        send(LOK, 1, 0, 0, 1, 0, "R3");
        bus_ev(1);
        lvl("R9", 1'b1, 1'b0);
        send(HR,    1, 1, 0, 1, 1, "R6");
        send(8'h99, 0, 0, 0, 1, 1, "R10");
        bus_ev(2);
        lvl("R8", 1'b0, 1'b0);

        // STOP wipes the memory
        bus_ev(0);
        send(HW,  1, 1, 0, 0, 0, "R2");
        send(LOK, 1, 0, 0, 1, 0, "R3");
        bus_ev(2);
        bus_ev(1);
        send(HR, 0, 0, 0, 0, 0, "R8");
        bus_ev(2);

        // plain START while selected drops it
        bus_ev(0);
        send(HW,  1, 1, 0, 0, 0, "R2");
        send(LOK, 1, 0, 0, 1, 0, "R3");
        bus_ev(0);
        lvl("R8", 1'b0, 1'b0);
        bus_ev(1);
        send(HR, 0, 0, 0, 0, 0, "R8");
        bus_ev(2);

        // mismatching header after repeated START drops selection and memory
        bus_ev(0);
        send(HW,  1, 1, 0, 0, 0, "R2");
        send(LOK, 1, 0, 0, 1, 0, "R3");
        bus_ev(1);
        send(HBAD, 0, 0, 0, 0, 0, "R9");
        bus_ev(1);
        send(HR, 0, 0, 0, 0, 0, "R9");
        bus_ev(2);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule